// File: doc/BRIEF.md
# Frame-Synchronous Serial Scrambler

This block whitens a serial bit stream with the self-restarting sequence of the polynomial 1 + x^6 + x^7. Each bit that is not held back is XORed with one bit of a keystream from a seven-stage shift register. The register is forced to all ones at the start of every frame. This keeps the keystream in step with the frame structure, so the far end can regenerate it exactly.

The framing bytes at the head of each frame must stay readable to the receiver's aligner. A bypass flag marks those bit times. While it is high, data passes through untouched and the keystream is frozen. XORing with the same keystream twice cancels out, so one copy of the block serves as the scrambler on the transmit side and another copy, fed with the received bits, serves as the descrambler.

Reset is asynchronous and active low. It is released into the block through a two-stage synchronizer, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `frame_scrambler`

## Requirements
- R1: While reset is held, `dout` is 0. After reset, the keystream state is all ones, so unbypassed bits with no frame pulse start at the first bit of the sequence.
- R2: The keystream bit is the last stage of the register. The value shifted into the first stage is the XOR of stages 6 and 7. Starting from all ones, the first ten keystream bits are 1,1,1,1,1,1,1,0,0,0, and the sequence repeats every 127 bits.
- R3: With `bypass` low, `dout` equals `din` XOR the current keystream bit, one clock after `din` is presented, and the keystream advances by one step.
- R4: With `bypass` high, `dout` equals `din` one clock later (the same latency as R3), and the keystream state does not change.
- R5: A `frame_start` pulse restarts the keystream at all ones. If the pulse comes on an unbypassed bit, that bit already uses keystream bit 0. If it comes during bypass, the restart waits for the first bit with `bypass` low. A pulse in mid-sequence also restarts.
- R6: A second instance that receives the first instance's `dout`, with `frame_start` and `bypass` delayed by one clock, returns the original `din` two clocks after it entered the first instance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse on the first bit time of a frame |
| bypass | input | 1 | High on bit times that pass unscrambled (framing bytes) |
| din | input | 1 | Serial data in |
| dout | output | 1 | Registered serial data out |

## Verification
An all-zero input after reset exposes the raw keystream. This separates a wrong tap or output stage from a wrong seed, and a run longer than 127 bits confirms the period. Random data in frames of random length, with a frame pulse under the framing-byte bypass and extra random bypass bits, tells a frozen keystream apart from one that slips during bypass. Directed frame pulses with bypass low, including one in mid-sequence, tell immediate restart apart from deferred restart. A chained receive instance checks that descrambling returns the original bits.

// File: rtl/fscr_pkg.sv
`timescale 1ns/1ps
package fscr_pkg;
  localparam int unsigned KS_LEN = 7;
  localparam int unsigned KS_TAP = 6;
  localparam int unsigned RST_STAGES = 2;

  typedef enum logic {
    MODE_SCRAMBLE = 1'b0,
    MODE_PASS     = 1'b1
  } bit_mode_e;
endpackage

// File: rtl/fscr_rst_sync.sv
`timescale 1ns/1ps
module fscr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/fscr_keystream.sv
`timescale 1ns/1ps
module fscr_keystream #(
  parameter int unsigned LEN = 7,
  parameter int unsigned TAP = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           hold,
  output logic           ks_bit,
  output logic [LEN-1:0] state,
  output logic           restart_pend
);
  localparam logic [LEN-1:0] SEED = '1;

  logic [LEN-1:0] state_d;
  logic [LEN-1:0] eff;
  logic           pend_d;
  logic           restart;
  logic           fb;

  // A restart pending or requested this bit selects the seed.
  always_comb begin
    restart = frame_start | restart_pend;
    eff     = restart ? SEED : state;
    ks_bit  = eff[LEN-1];
    fb      = eff[LEN-1] ^ eff[TAP-1];
  end

  // Next state, with the clock enable (not hold) written out.
  always_comb begin
    state_d = state;
    pend_d  = restart_pend | frame_start;
    if (!hold) begin
      state_d = {eff[LEN-2:0], fb};
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SEED;
      restart_pend <= 1'b0;
    end else begin
      state        <= state_d;
      restart_pend <= pend_d;
    end
  end
endmodule

// File: rtl/fscr_datapath.sv
`timescale 1ns/1ps
module fscr_datapath
  import fscr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bit_mode_e mode,
  input  logic      din,
  input  logic      ks_bit,
  output logic      dout
);
  logic dout_d;

  always_comb begin
    unique case (mode)
      MODE_PASS:     dout_d = din;
      MODE_SCRAMBLE: dout_d = din ^ ks_bit;
      default:       dout_d = din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= dout_d;
  end
endmodule

// File: rtl/frame_scrambler.sv
`timescale 1ns/1ps
module frame_scrambler
  import fscr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic bypass,
  input  logic din,
  output logic dout
);
  logic              rst_s;
  logic              ks_bit;
  logic [KS_LEN-1:0] ks_state;
  logic              reload_pend;
  bit_mode_e         mode;

  assign mode = bypass ? MODE_PASS : MODE_SCRAMBLE;

  fscr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  fscr_keystream #(.LEN(KS_LEN), .TAP(KS_TAP)) u_ks (
    .clk          (clk),
    .rst_n        (rst_s),
    .frame_start  (frame_start),
    .hold         (bypass),
    .ks_bit       (ks_bit),
    .state        (ks_state),
    .restart_pend (reload_pend)
  );

  fscr_datapath u_dp (
    .clk    (clk),
    .rst_n  (rst_s),
    .mode   (mode),
    .din    (din),
    .ks_bit (ks_bit),
    .dout   (dout)
  );
endmodule

// File: rtl/fscr_checker.sv
`timescale 1ns/1ps
module fscr_checker #(
  parameter int unsigned LEN = 7
) (
  input logic           clk,
  input logic           rst_s,
  input logic           frame_start,
  input logic           bypass,
  input logic           din,
  input logic           dout,
  input logic [LEN-1:0] ks_state,
  input logic           reload_pend
);
  localparam logic [LEN-1:0] AFTER_SEED = {{(LEN-1){1'b1}}, 1'b0};

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_s)
    bypass |=> dout == $past(din)); // R4
  AST_KS_FROZEN: assert property (@(posedge clk) disable iff (!rst_s)
    bypass |=> ks_state == $past(ks_state)); // R4
  AST_RESTART_FLIPS: assert property (@(posedge clk) disable iff (!rst_s)
    (!bypass && (frame_start || reload_pend)) |=> dout != $past(din)); // R5
  AST_RESTART_STATE: assert property (@(posedge clk) disable iff (!rst_s)
    (!bypass && (frame_start || reload_pend)) |=> ks_state == AFTER_SEED); // R5
  AST_SCRAMBLE_XOR: assert property (@(posedge clk) disable iff (!rst_s)
    (!bypass && !frame_start && !reload_pend)
      |=> dout == ($past(din) ^ $past(ks_state[LEN-1]))); // R3
  AST_STATE_LIVE: assert property (@(posedge clk) disable iff (!rst_s)
    ks_state != '0); // R2
endmodule

bind frame_scrambler fscr_checker #(.LEN(fscr_pkg::KS_LEN)) u_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .frame_start (frame_start),
  .bypass      (bypass),
  .din         (din),
  .dout        (dout),
  .ks_state    (ks_state),
  .reload_pend (reload_pend)
);

// File: tb/frame_scrambler_test.sv
`timescale 1ns/1ps
module frame_scrambler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, byp = 1'b1, d = 1'b0;
  logic rx_fs = 1'b0, rx_byp = 1'b1, rx_d = 1'b0;
  logic tx_out, rx_out;

  int checks = 0, fails = 0;
  bit done = 0;
  bit seq [127];
  int idx = 0;
  bit pend = 0;
  bit tx_v = 0, rx_v = 0, p_v = 0;
  logic tx_exp, rx_exp;
  logic p_fs = 1'b0, p_byp = 1'b1, p_d = 1'b0;
  string tx_tag = "R3";
  logic last_tx;

  always #10 clk = ~clk;

  frame_scrambler uut (.clk(clk), .rst_n(rst_n), .frame_start(fs), .bypass(byp),
                       .din(d), .dout(tx_out));
  frame_scrambler uut_rx (.clk(clk), .rst_n(rst_n), .frame_start(rx_fs), .bypass(rx_byp),
                          .din(rx_d), .dout(rx_out));

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Sequence from the requirement: output last stage, feed back stage6 ^ stage7.
  function automatic void build_seq();
    bit [6:0] s = 7'h7F;
    for (int i = 0; i < 127; i++) begin
      seq[i] = s[6];
      s = {s[5:0], s[5] ^ s[6]};
    end
  endfunction

  task automatic step(input logic f, input logic b, input logic x);
    @(negedge clk);
    last_tx = tx_out;
    if (tx_v) check(tx_out, tx_exp, tx_tag);
    if (rx_v) check(rx_out, rx_exp, "R6");
    rx_d   = tx_out;
    rx_fs  = p_fs;
    rx_byp = p_byp;
    rx_exp = p_d;
    rx_v   = p_v;
    fs = f; byp = b; d = x;
    if (f) pend = 1;
    if (b) begin
      tx_exp = x;
      tx_tag = "R4";
    end else begin
      tx_tag = pend ? "R5" : "R3";
      if (pend) begin idx = 0; pend = 0; end
      tx_exp = x ^ seq[idx % 127];
      idx++;
    end
    tx_v = 1;
    p_fs = f; p_byp = b; p_d = x; p_v = 1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [9:0] cap = '0;
    void'($urandom(32'd20240611));
    build_seq();
    // R1: output low while reset held
    repeat (3) @(negedge clk);
    check(tx_out, 1'b0, "R1");
    check(rx_out, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_out, 1'b0, "R1");

    // R1/R2: zeros expose keystream from the reset seed
    for (int i = 0; i < 11; i++) begin
      step(1'b0, 1'b0, 1'b0);
      if (i >= 1) cap = {cap[8:0], last_tx};
    end
    check(cap == 10'b1111111000, 1'b1, "R2");

    // R2: run past the 127-bit period
    for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 1'($urandom));

    // R5: pulse with bypass low in mid-sequence
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'($urandom));

    // R5 and R4: pulse under bypass, restart deferred
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'($urandom));
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 1'($urandom));
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'($urandom));

    // R4: bypass in mid-sequence freezes the keystream
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'($urandom));
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'($urandom));

    // Random frames: framing bytes bypassed, sporadic extra bypass bits
    for (int f = 0; f < 6; f++) begin
      int len = 200 + int'($urandom % 300);
      for (int i = 0; i < len; i++) begin
        logic b = (i < 16) ? 1'b1 : (($urandom % 16) == 0);
        step((i == 0), b, 1'($urandom));
      end
    end

    // Flush so the last bits of both instances are compared
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule